// File: doc/BRIEF.md
# Fractional Divider Modulus Controller

This block decides, once per feedback-divider cycle, whether a dual-modulus divider should divide by N or by N+1, so that the long-run average division ratio is N plus a binary fraction K/2^k. A strobe from the divider output marks each cycle. On every strobe the block registers a new select bit and the matching divide value, and both hold steady until the next strobe.

Two selection policies share the same pins. In accumulator mode a k-bit phase accumulator adds the fractional word on each strobe, and its carry picks N+1. This gives a periodic, deterministic pattern. In random mode a k-bit maximal-length pseudorandom generator supplies a fresh word on each strobe. N+1 is chosen whenever that word is below the fractional word, which breaks up the periodic pattern while keeping the same average.

Top module: `fracdiv_modsel`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears sel_hi, div_value and the accumulator to zero, and loads the generator state from seed.
- R2: In accumulator mode (mode_rand = 0), each strobe replaces the accumulator A with (A + frac_word) mod 2^k. sel_hi becomes 1 exactly when A + frac_word is at least 2^k.
- R3: In accumulator mode, any 2^k consecutive strobes with a fixed fractional word p give exactly p strobes with sel_hi = 1.
- R4: With k = 4 and frac_word = 4 (one quarter), the sel_hi sequence after reset is 0,0,0,1 and then repeats.
- R5: In random mode (mode_rand = 1), each strobe sets sel_hi to 1 exactly when the current generator word Pn is below frac_word. The generator then advances one step. A step is a right shift, and when the bit shifted out is 1 the result is XORed with a mask. For k = 4 the mask is 4'hC. Supported widths are 3 to 11 and 16.
- R6: In random mode, any 2^k - 1 consecutive strobes with a fixed word K give exactly max(K - 1, 0) strobes with sel_hi = 1.
- R7: A zero seed loads the generator as 1, so its output sequence is the same as with seed 1.
- R8: sel_hi and div_value change only on a clock edge where div_strobe is high. Changes to the mode, the fractional word or N between strobes have no effect on the outputs.
- R9: On each strobe, div_value is registered as int_n + sel_hi, using the int_n present at that strobe.
- R10: A fractional word of zero never selects N+1 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_strobe | input | 1 | One-cycle pulse per divider output cycle |
| int_n | input | INT_W | Integer division ratio N |
| frac_word | input | FRAC_W | Fractional word (p or K) |
| mode_rand | input | 1 | 0 = accumulator mode, 1 = random mode |
| seed | input | FRAC_W | Generator seed, loaded at reset |
| sel_hi | output | 1 | 1 = divide by N+1 this cycle |
| div_value | output | INT_W+1 | Registered divide value N + sel_hi |

## Verification
The bench builds the block with FRAC_W = 4 and INT_W = 6. At that width every one of the sixteen fractional words can be swept through a full accumulator period of 16 strobes, and through a full generator period of 15 strobes. The N+1 counts can then be compared with the closed forms p and K-1. The small width also keeps the generator steps from a given seed short enough to work out by hand for the reset, the one-quarter pattern and the zero-seed cases.

// File: rtl/fracdiv_pkg.sv
`timescale 1ns/1ps
package fracdiv_pkg;

    typedef enum logic {
        MODE_ACC  = 1'b0,
        MODE_RAND = 1'b1
    } sel_mode_e;

    // Galois right-shift feedback masks giving maximal-length sequences
    function automatic logic [31:0] lfsr_mask(input int width);
        case (width)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            16:      return 32'h0000_B400;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/fracdiv_phase_acc.sv
`timescale 1ns/1ps
module fracdiv_phase_acc #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);
    localparam int SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, frac_i};
        carry_o = sum[SUM_W-1];
        st_d    = st_q;
        if (step_i) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a zero word never produces a carry
    p_zero_word_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_i == '0) |-> !carry_o);

endmodule

// File: rtl/fracdiv_lfsr.sv
`timescale 1ns/1ps
module fracdiv_lfsr
    import fracdiv_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] seed_i,
    output logic [FRAC_W-1:0] word_o
);
    localparam logic [FRAC_W-1:0] MASK = FRAC_W'(lfsr_mask(FRAC_W));
    localparam logic [FRAC_W-1:0] ONE  = FRAC_W'(1);

    typedef struct packed {
        logic [FRAC_W-1:0] state;
    } gen_state_t;

    gen_state_t        st_d, st_q;
    logic [FRAC_W-1:0] load_val;

    always_comb begin
        load_val = (seed_i == '0) ? ONE : seed_i;
        st_d     = st_q;
        if (step_i) begin
            st_d.state = (st_q.state >> 1) ^ (st_q.state[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= load_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.state;

    // R7: the generator never reaches the all-zero lock-up state
    p_state_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_o != '0);

    // R5: the generator moves only when stepped
    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(word_o));

endmodule

// File: rtl/fracdiv_modsel.sv
`timescale 1ns/1ps
module fracdiv_modsel
    import fracdiv_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int INT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_strobe,
    input  logic [INT_W-1:0]  int_n,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic              mode_rand,
    input  logic [FRAC_W-1:0] seed,
    output logic              sel_hi,
    output logic [INT_W:0]    div_value
);
    localparam int DIV_W = INT_W + 1;

    typedef struct packed {
        logic             sel;
        logic [DIV_W-1:0] div;
    } out_state_t;

    sel_mode_e         mode;
    logic              acc_step, gen_step;
    logic              carry_w;
    logic [FRAC_W-1:0] pn_w;
    logic              pick_hi;
    out_state_t        out_d, out_q;

    assign mode     = sel_mode_e'(mode_rand);
    assign acc_step = div_strobe && (mode == MODE_ACC);
    assign gen_step = div_strobe && (mode == MODE_RAND);

    fracdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (acc_step),
        .frac_i  (frac_word),
        .carry_o (carry_w)
    );

    fracdiv_lfsr #(.FRAC_W(FRAC_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (gen_step),
        .seed_i (seed),
        .word_o (pn_w)
    );

    always_comb begin
        pick_hi = (mode == MODE_RAND) ? (pn_w < frac_word) : carry_w;
        out_d   = out_q;
        if (div_strobe) begin
            out_d.sel = pick_hi;
            out_d.div = {1'b0, int_n} + DIV_W'(pick_hi);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_hi    = out_q.sel;
    assign div_value = out_q.div;

    // R9: the divide value is the strobe-time N plus the select bit
    p_div_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_strobe |=> div_value == {1'b0, $past(int_n)} + DIV_W'(sel_hi));

    // R8: outputs hold between strobes
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_strobe |=> ($stable(sel_hi) && $stable(div_value)));

    // R10: a zero fractional word never picks N+1
    p_zero_frac_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_strobe && frac_word == '0) |=> !sel_hi);

endmodule

// File: tb/fracdiv_modsel_test.sv
`timescale 1ns/1ps
module fracdiv_modsel_test;
    localparam int FW = 4;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_strobe = 1'b0;
    logic [IW-1:0] int_n = '0;
    logic [FW-1:0] frac_word = '0;
    logic          mode_rand = 1'b0;
    logic [FW-1:0] seed = 4'd5;
    logic          sel_hi;
    logic [IW:0]   div_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fracdiv_modsel #(.FRAC_W(FW), .INT_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .div_strobe(div_strobe), .int_n(int_n),
        .frac_word(frac_word), .mode_rand(mode_rand), .seed(seed),
        .sel_hi(sel_hi), .div_value(div_value)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [FW-1:0] s);
        @(negedge clk);
        seed  = s;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one strobe, outputs sampled at the following falling edge
    task automatic strobe();
        @(negedge clk);
        div_strobe = 1'b1;
        @(negedge clk);
        div_strobe = 1'b0;
    endtask

    initial begin
        int acc;
        int ones;
        int s0 [2];
        // R1: reset state
        do_reset(4'd5);
        check("R1 sel after reset", sel_hi, 0);
        check("R1 div after reset", div_value, 0);
        // R1/R5: seed 5, K=6: Pn=5 -> 1, then Pn=14 -> 0
        mode_rand = 1'b1; frac_word = 4'd6; int_n = 6'd10;
        strobe();
        check("R5 first random select", sel_hi, 1);
        check("R9 first random div", div_value, 11);
        strobe();
        check("R5 second random select", sel_hi, 0);
        check("R9 second random div", div_value, 10);

        // R8: input changes between strobes are ignored
        mode_rand = 1'b0; frac_word = 4'd15; int_n = 6'd33;
        repeat (5) @(negedge clk);
        check("R8 sel held", sel_hi, 0);
        check("R8 div held", div_value, 10);

        // R4: one quarter gives 0,0,0,1 repeating
        do_reset(4'd5);
        mode_rand = 1'b0; frac_word = 4'd4; int_n = 6'd7;
        for (int i = 0; i < 8; i++) begin
            strobe();
            check("R4 quarter pattern", sel_hi, (i % 4 == 3) ? 1 : 0);
        end

        // R2/R3/R9/R10: accumulator sweep, arithmetic model
        do_reset(4'd5);
        acc = 0;
        for (int p = 0; p < 16; p++) begin
            frac_word = FW'(p); int_n = IW'(20 + p); ones = 0;
            for (int j = 0; j < 16; j++) begin
                int e;
                strobe();
                e = (acc + p >= 16) ? 1 : 0;
                acc = (acc + p) % 16;
                ones += sel_hi;
                check("R2 accumulator carry", sel_hi, e);
                check("R9 accumulator div", div_value, 20 + p + e);
            end
            check("R3 accumulator average", ones, p);
            if (p == 0) check("R10 zero word accumulator", ones, 0);
        end

        // R6/R10: random sweep over a full generator period per word
        mode_rand = 1'b1;
        for (int k = 0; k < 16; k++) begin
            frac_word = FW'(k); ones = 0;
            for (int j = 0; j < 15; j++) begin
                strobe();
                ones += sel_hi;
            end
            check("R6 random average", ones, (k > 0) ? k - 1 : 0);
            if (k == 0) check("R10 zero word random", ones, 0);
        end

        // R7: zero seed behaves as seed 1 (Pn=1 -> 1, then 12 -> 0)
        do_reset(4'd0);
        mode_rand = 1'b1; frac_word = 4'd2;
        strobe(); s0[0] = sel_hi;
        strobe(); s0[1] = sel_hi;
        check("R7 zero seed first", s0[0], 1);
        check("R7 zero seed second", s0[1], 0);
        do_reset(4'd1);
        strobe();
        check("R7 seed one first", sel_hi, s0[0]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule